// File: doc/BRIEF.md
# Echo Delay-Line Memory Sequencer

This block turns one single-port static RAM into a fixed-length circular delay line for an audio echo effect. It runs from a timing clock at twice the audio sample rate (88.2 kHz for 44.1 kHz audio). Each sample period has exactly two timing ticks. In the first tick the RAM is read at the current address, which replays the sample stored one full buffer ago. In the second tick the new converter sample is written to that same address. An address counter then moves on by one and wraps around, so every sample comes back out after exactly 2^ADDR_W sample periods (65536 with the default width).

The RAM output-enable is driven during the read tick. The RAM write-enable and the converter output-enable are driven together during the write tick, so the converter places its word on the RAM data pins. The replayed word is captured into an output register, and `dac_valid` pulses once per sample period when that register changes. The audio rate is fixed, so the outgoing stream has no ready input and cannot be back-pressured. The consumer must take each word in the cycle `dac_valid` is high, and the word then stays stable for one full sample period. The converter has no handshake either: its sample must be present on `adc_sample` whenever `adc_oe` is high.

Top module: `echo_delay_ctrl`

## Requirements
- R1: While the synchronous active-high `rst` is high, and in the first cycle after it, `ram_oe`, `ram_we`, `adc_oe` and `dac_valid` are 0 and `ram_addr` is 0.
- R2: After reset is released, the block runs one read cycle (`ram_oe`=1) and then one write cycle (`ram_we`=1), alternating with no idle cycle, and the first of them is a read.
- R3: `ram_oe` and `ram_we` are never 1 in the same cycle, and `adc_oe` is 1 exactly in the cycles where `ram_we` is 1.
- R4: `ram_addr` holds the same value in the read cycle and in the write cycle of one sample, and rises by one for the next sample. The first sample after reset uses address 0.
- R5: After the write cycle at address 2^ADDR_W-1, the next read cycle uses address 0.
- R6: `dac_sample` takes the RAM word present during the read cycle. In the following cycle (the write cycle), `dac_valid` is 1 and `dac_sample` shows that word. `dac_valid` is 1 for exactly one cycle in each sample period.
- R7: A word written from `adc_sample` in sample period k appears on `dac_sample` in sample period k+2^ADDR_W. `ram_wdata` carries `adc_sample` unchanged.
- R8: A reset asserted in the middle of operation returns the block to the R1 state. The sequence then restarts with a read at address 0, and the RAM contents are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, two ticks per sample period |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample | input | DATA_W | Sample from the converter, valid while `adc_oe` is high |
| adc_oe | output | 1 | Lets the converter drive the RAM data pins (write tick) |
| ram_addr | output | ADDR_W | RAM address, one per sample period |
| ram_oe | output | 1 | RAM output-enable (read tick) |
| ram_we | output | 1 | RAM write-enable (write tick) |
| ram_wdata | output | DATA_W | Word written into the RAM |
| ram_rdata | input | DATA_W | Word read from the RAM |
| dac_sample | output | DATA_W | Delayed sample to the DAC |
| dac_valid | output | 1 | One-cycle pulse when `dac_sample` updates |

## Verification
The strobes and the address are decoded from registers, so they change one edge after reset is released, and every following edge flips between read and write. The replayed word is registered at the edge that ends the read tick, so it is due, together with `dac_valid`, in the write tick of the same sample. A word written in sample k is due back 2^ADDR_W sample periods later, which is 2·2^ADDR_W clock cycles. The bench drives inputs and samples outputs on the falling clock edge. It tracks the sample index from the write ticks it observes, and it computes the expected address and replayed word from that index. The bench uses a 32-word buffer, so the wrap and the full delay are both crossed twice.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/echo_sequencer.sv
// Two-tick sample sequencer: read tick, then write tick, repeated.
module echo_sequencer
  import echo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic rd_tick,
  output logic wr_tick
);
  phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_IDLE:  phase_d = PH_READ;
      PH_READ:  phase_d = PH_WRITE;
      PH_WRITE: phase_d = PH_READ;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  assign rd_tick = (phase_q == PH_READ);
  assign wr_tick = (phase_q == PH_WRITE);
endmodule

// File: rtl/echo_addr_counter.sv
// Circular sample address; steps once per sample period.
module echo_addr_counter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      addr <= '0;
    else if (step)
      addr <= (addr == LAST) ? '0 : addr + ONE;
  end
endmodule

// File: rtl/echo_capture.sv
// Holds the replayed word for one sample period and flags its update.
module echo_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              fresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= load;
      if (load) dout <= din;
    end
  end
endmodule

// File: rtl/echo_delay_ctrl.sv
module echo_delay_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] adc_sample,
  output logic              adc_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_oe,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] dac_sample,
  output logic              dac_valid
);
  logic rd_tick, wr_tick;

  echo_sequencer u_seq (
    .clk     (clk),
    .rst     (rst),
    .rd_tick (rd_tick),
    .wr_tick (wr_tick)
  );

  // Address moves on at the edge that closes the write tick.
  echo_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .step (wr_tick),
    .addr (ram_addr)
  );

  // Replayed word is captured at the edge that closes the read tick.
  echo_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .load  (rd_tick),
    .din   (ram_rdata),
    .dout  (dac_sample),
    .fresh (dac_valid)
  );

  assign ram_oe    = rd_tick;
  assign ram_we    = wr_tick;
  assign adc_oe    = wr_tick;
  assign ram_wdata = adc_sample;
endmodule

// File: rtl/echo_delay_ctrl_chk.sv
module echo_delay_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              adc_oe,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_oe,
  input logic              ram_we,
  input logic              dac_valid
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

  // R1: reset leaves strobes off and address at zero
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!ram_oe && !ram_we && !adc_oe && !dac_valid && ram_addr == '0));

  // R2: read is followed by write, write by read
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (rst)
    ram_oe |=> ram_we);
  a_r2_write_then_read: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> ram_oe);

  // R3: strobes exclusive, converter enabled only with write
  a_r3_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(ram_oe && ram_we));
  a_r3_adc_with_write: assert property (@(posedge clk) disable iff (rst)
    adc_oe |-> (ram_we && !ram_oe));

  // R4: address held across one sample, then stepped
  a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
    ram_oe |=> $stable(ram_addr));
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ram_we && ram_addr != LAST) |=> (ram_addr == $past(ram_addr) + ONE));

  // R5: wrap to zero
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (ram_we && ram_addr == LAST) |=> (ram_addr == '0));

  // R6: one valid pulse, in the tick after the read
  a_r6_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    ram_oe |=> dac_valid);
  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    dac_valid |=> !dac_valid);
endmodule

bind echo_delay_ctrl echo_delay_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .adc_oe    (adc_oe),
  .ram_addr  (ram_addr),
  .ram_oe    (ram_oe),
  .ram_we    (ram_we),
  .dac_valid (dac_valid)
);

// File: tb/echo_delay_ctrl_tb.sv
module echo_delay_ctrl_tb;
  localparam int AW    = 5;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int NSAMP = 80;

  // Stimulus table: audio words mixed with the sample index per write.
  localparam logic [DW-1:0] SAMPLE_TAB [8] = '{
    16'h7FF0, 16'h0123, 16'hC0DE, 16'h8001,
    16'h3C3C, 16'hFFFF, 16'h0000, 16'h5A5A
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] adc_sample = '0;
  logic          adc_oe, ram_oe, ram_we, dac_valid;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata, dac_sample;
  logic [DW-1:0] mem [DEPTH];

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  echo_delay_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .adc_sample(adc_sample), .adc_oe(adc_oe),
    .ram_addr(ram_addr), .ram_oe(ram_oe), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .dac_sample(dac_sample), .dac_valid(dac_valid)
  );

  // RAM model: asynchronous read, write at the clock edge.
  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  function automatic logic [DW-1:0] init_word(int i);
    return 16'hA5A5 ^ DW'(i * 97);
  endfunction

  function automatic logic [DW-1:0] new_word(int k);
    return SAMPLE_TAB[k % 8] ^ DW'(k);
  endfunction

  function automatic logic [DW-1:0] replay_word(int k);
    return (k < DEPTH) ? init_word(k) : new_word(k - DEPTH);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = init_word(i);
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check("R1 ram_oe", int'(ram_oe), 0);
    check("R1 ram_we", int'(ram_we), 0);
    check("R1 adc_oe", int'(adc_oe), 0);
    check("R1 dac_valid", int'(dac_valid), 0);
    check("R1 ram_addr", int'(ram_addr), 0);
    rst = 1'b0;

    // Table walk: one loop over the stream of read/write ticks.
    k = 0;
    while (k < NSAMP) begin
      @(negedge clk);
      check("R3 oe/we exclusive", int'(ram_oe && ram_we), 0);
      check("R3 adc_oe follows we", int'(adc_oe), int'(ram_we));
      if (ram_oe) begin
        check("R4 read address", int'(ram_addr), k % DEPTH);
        check("R6 no valid in read", int'(dac_valid), 0);
      end else if (ram_we) begin
        check((k % DEPTH == 0 && k > 0) ? "R5 wrap address" : "R4 write address",
              int'(ram_addr), k % DEPTH);
        check("R6 valid in write", int'(dac_valid), 1);
        check(k < DEPTH ? "R6 replayed word" : "R7 delayed word",
              int'(dac_sample), int'(replay_word(k)));
        adc_sample = new_word(k);
        check("R7 wdata from converter", int'(ram_wdata), int'(new_word(k)));
        k++;
      end else begin
        check("R2 no idle tick", 0, 1);
        k++;
      end
    end

    // R8: reset in the middle of operation
    @(negedge clk);
    check("R2 read after write", int'(ram_oe), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R8 oe cleared", int'(ram_oe), 0);
    check("R8 we cleared", int'(ram_we), 0);
    check("R8 addr cleared", int'(ram_addr), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 restart read", int'(ram_oe), 1);
    check("R8 restart addr", int'(ram_addr), 0);
    @(negedge clk);
    check("R8 restart write", int'(ram_we), 1);
    check("R8 memory kept", int'(dac_sample), int'(new_word(64)));
    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule